// File: doc/BRIEF.md
# Compact Memory Trace Record Formatter

This block turns a stream of snooped memory references into a dense stream of 32-bit trace words. Each reference arrives with its bank, row, column, direction and a sample of a free-running tick counter. Every record holds the tick difference since the previous record rather than an absolute time, so one record fits in four bytes. A separate overflow word carries a difference that is too large for the record's time field, so a replay tool can still rebuild absolute time.

Column accesses that belong to a burst already recorded are dropped, so only the first address of each burst reaches the stream. Event markers from a control decoder enter the same stream as tag words. Finished words go into a multi-entry FIFO that absorbs bursts of activity. The FIFO drains through a valid/ready transmit port. When the FIFO cannot take a whole record group, the group is discarded and a sticky loss flag is raised.

Top module: `trc_formatter`

## Requirements
- R1: After reset `tx_valid` and `lost` are 0 and the tick reference is 0.
- R2: An access word has bit 31 = 0, bit 30 = `acc_write`, bits 29:22 = the 8-bit delta, and bits 21:0 = the line address {bank, row, column without its low `BURST_LOG2` bits}.
- R3: The delta is `ts` minus the `ts` of the last record group written to the FIFO, modulo 2^`TS_W`. Only groups actually written move the reference.
- R4: When the delta exceeds 255, an overflow word {1, subtype 3'b001 in bits 30:28, delta in bits 27:0} is written first and the record that follows carries delta 0. A delta of exactly 255 needs no overflow word.
- R5: An access is dropped with no word when it has the same bank, row and direction as the most recently presented access and its column lies in the same aligned window of 2^`BURST_LOG2` columns. Every presented access becomes the new comparison point.
- R6: A marker writes a tag word {1, subtype 3'b010 in bits 30:28, delta in bits 27:20, zeros in 19:16, code in 15:0}. It is preceded by an overflow word under the R4 rule, and it moves the tick reference like an access.
- R7: When a marker and a kept access arrive in the same cycle, the marker's words come first and the access word carries delta 0.
- R8: Words leave in the order they were written. `tx_valid` is high exactly while the FIFO holds a word, and `tx_data` holds steady while `tx_valid` is high and `tx_ready` is low.
- R9: When the FIFO's free space is smaller than a cycle's whole group, no word of that group is written, the tick reference is left unchanged, and `lost` becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts | input | TS_W | Free-running tick counter sample |
| acc_valid | input | 1 | A memory access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_bank | input | BANK_W | Bank of the access |
| acc_row | input | ROW_W | Row of the access |
| acc_col | input | COL_W | Column of the access |
| mark_valid | input | 1 | An event marker is presented this cycle |
| mark_code | input | 16 | Event code of the marker |
| tx_valid | output | 1 | A trace word is available |
| tx_data | output | 32 | Trace word at the head of the FIFO |
| tx_ready | input | 1 | Consumer takes the word this cycle |
| lost | output | 1 | Sticky flag: a record group was discarded |

## Verification
Directed sequences use tick steps of exactly 255 and 256 to separate the plain record from the overflow pair. Bursts walk the columns of one window and then cross into the next window, a different bank and the other direction, which shows whether dedupe compares the right fields. Markers appear alone and together with an access, which exposes the word order and the delta-0 rule. A stalled consumer fills the FIFO to check the discard and the flag. A long seeded random run then mixes a small address pool, rare markers, occasional large tick gaps and a random ready signal, so dedupe, overflow and backpressure all interact.

// File: rtl/trc_pkg.sv
package trc_pkg;
    localparam int WORD_W  = 32;
    localparam int DELTA_W = 8;
    localparam int LINE_W  = 22;
    localparam int PAY_W   = 28;
    localparam int CODE_W  = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        SUB_OVF = 3'd1,
        SUB_TAG = 3'd2
    } sub_e;

    function automatic word_t mk_access(logic wr, logic [DELTA_W-1:0] dt, logic [LINE_W-1:0] line);
        return {1'b0, wr, dt, line};
    endfunction

    function automatic word_t mk_ovf(logic [PAY_W-1:0] pay);
        return {1'b1, SUB_OVF, pay};
    endfunction

    function automatic word_t mk_tag(logic [DELTA_W-1:0] dt, logic [CODE_W-1:0] code);
        return {1'b1, SUB_TAG, dt, 4'b0000, code};
    endfunction
endpackage

// File: rtl/trc_burst_filter.sv
module trc_burst_filter #(
    parameter int BANK_W     = 3,
    parameter int ROW_W      = 13,
    parameter int COL_W      = 8,
    parameter int BURST_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [BANK_W-1:0] acc_bank,
    input  logic [ROW_W-1:0]  acc_row,
    input  logic [COL_W-1:0]  acc_col,
    output logic              acc_keep
);
    localparam int WIN_W = COL_W - BURST_LOG2;

    typedef struct packed {
        logic              have;
        logic              wr;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [WIN_W-1:0]  win;
    } st_t;

    st_t st_d, st_q;
    logic follow;
    logic unused_col_bits;

    assign unused_col_bits = ^acc_col[BURST_LOG2-1:0];

    always_comb begin
        st_d   = st_q;
        follow = st_q.have && (st_q.wr == acc_write) && (st_q.bank == acc_bank)
              && (st_q.row == acc_row) && (st_q.win == acc_col[COL_W-1:BURST_LOG2]);
        acc_keep = acc_valid && !follow;
        if (acc_valid) begin
            st_d.have = 1'b1;
            st_d.wr   = acc_write;
            st_d.bank = acc_bank;
            st_d.row  = acc_row;
            st_d.win  = acc_col[COL_W-1:BURST_LOG2];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: an access repeating last cycle's bank/row/direction/window is never kept
    a_r5_repeat_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && acc_valid && $past(acc_valid) && acc_write == $past(acc_write)
         && acc_bank == $past(acc_bank) && acc_row == $past(acc_row)
         && acc_col[COL_W-1:BURST_LOG2] == $past(acc_col[COL_W-1:BURST_LOG2])) |-> !acc_keep);
endmodule

// File: rtl/trc_packer.sv
module trc_packer
    import trc_pkg::*;
#(
    parameter int TS_W = 28
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TS_W-1:0]       ts,
    input  logic                  mark_valid,
    input  logic [CODE_W-1:0]     mark_code,
    input  logic                  acc_keep,
    input  logic                  acc_write,
    input  logic [LINE_W-1:0]     acc_line,
    input  logic                  commit,
    output logic [2:0][WORD_W-1:0] grp_words,
    output logic [1:0]            grp_cnt
);
    typedef struct packed {
        logic [TS_W-1:0] ref_ts;
    } st_t;

    st_t st_d, st_q;
    logic [TS_W-1:0]    delta;
    logic               big;
    logic [DELTA_W-1:0] dt;
    logic [1:0]         n;

    always_comb begin
        st_d      = st_q;
        delta     = ts - st_q.ref_ts;
        big       = delta > TS_W'(255);
        dt        = big ? '0 : delta[DELTA_W-1:0];
        grp_words = '0;
        n         = 2'd0;
        if (mark_valid) begin
            if (big) begin
                grp_words[n] = mk_ovf(PAY_W'(delta));
                n = n + 2'd1;
            end
            grp_words[n] = mk_tag(dt, mark_code);
            n = n + 2'd1;
        end
        if (acc_keep) begin
            if (mark_valid) begin
                grp_words[n] = mk_access(acc_write, '0, acc_line);
            end else begin
                if (big) begin
                    grp_words[n] = mk_ovf(PAY_W'(delta));
                    n = n + 2'd1;
                end
                grp_words[n] = mk_access(acc_write, dt, acc_line);
            end
            n = n + 2'd1;
        end
        grp_cnt = n;
        if (commit && n != 2'd0) st_d.ref_ts = ts;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a group that opens with an overflow word always carries a record after it
    a_r4_ovf_followed: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_cnt != 2'd0 && grp_words[0][31:28] == {1'b1, SUB_OVF}) |-> grp_cnt >= 2'd2);
endmodule

// File: rtl/trc_fifo.sv
module trc_fifo
    import trc_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             push_cnt,
    input  logic [2:0][WORD_W-1:0] push_words,
    output logic                   push_ok,
    output logic                   tx_valid,
    output logic [WORD_W-1:0]      tx_data,
    input  logic                   tx_ready,
    output logic                   lost
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = AW + 1;

    typedef struct packed {
        logic [AW-1:0]    wptr;
        logic [AW-1:0]    rptr;
        logic [CNT_W-1:0] count;
        logic             lost;
    } st_t;

    st_t st_d, st_q;
    word_t mem [DEPTH];
    logic [CNT_W-1:0] free;
    logic do_push, do_pop;

    always_comb begin
        st_d     = st_q;
        free     = CNT_W'(DEPTH) - st_q.count;
        push_ok  = free >= CNT_W'(push_cnt);
        do_push  = push_ok && push_cnt != 2'd0;
        do_pop   = st_q.count != '0 && tx_ready;
        tx_valid = st_q.count != '0;
        tx_data  = mem[st_q.rptr];
        if (do_push) st_d.wptr = st_q.wptr + AW'(push_cnt);
        if (do_pop)  st_d.rptr = st_q.rptr + AW'(1);
        st_d.count = st_q.count + (do_push ? CNT_W'(push_cnt) : '0) - (do_pop ? CNT_W'(1) : '0);
        if (push_cnt != 2'd0 && !push_ok) st_d.lost = 1'b1;
        lost = st_q.lost;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < 3; k++) begin
            if (do_push && k < int'(push_cnt)) mem[st_q.wptr + AW'(k)] <= push_words[k];
        end
    end

    // R8: the head word holds while the consumer stalls
    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    // R9: the loss flag never clears outside reset
    a_r9_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(lost) |-> lost);
    // R9: a refused group raises the flag on the next cycle
    a_r9_refuse_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (push_cnt != 2'd0 && !push_ok) |=> lost);
    // R9: occupancy never passes the depth
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));
endmodule

// File: rtl/trc_formatter.sv
module trc_formatter
    import trc_pkg::*;
#(
    parameter int BANK_W     = 3,
    parameter int ROW_W      = 13,
    parameter int COL_W      = 8,
    parameter int BURST_LOG2 = 2,
    parameter int TS_W       = 28,
    parameter int FIFO_DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   ts,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [BANK_W-1:0] acc_bank,
    input  logic [ROW_W-1:0]  acc_row,
    input  logic [COL_W-1:0]  acc_col,
    input  logic              mark_valid,
    input  logic [15:0]       mark_code,
    output logic              tx_valid,
    output logic [31:0]       tx_data,
    input  logic              tx_ready,
    output logic              lost
);
    localparam int FULL_W = BANK_W + ROW_W + COL_W - BURST_LOG2;

    logic                   acc_keep;
    logic [FULL_W-1:0]      full_line;
    logic [LINE_W-1:0]      acc_line;
    logic [2:0][WORD_W-1:0] grp_words;
    logic [1:0]             grp_cnt;
    logic                   push_ok;

    assign full_line = {acc_bank, acc_row, acc_col[COL_W-1:BURST_LOG2]};
    assign acc_line  = LINE_W'(full_line);

    trc_burst_filter #(
        .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .BURST_LOG2(BURST_LOG2)
    ) u_filter (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_bank(acc_bank), .acc_row(acc_row), .acc_col(acc_col), .acc_keep(acc_keep)
    );

    trc_packer #(.TS_W(TS_W)) u_packer (
        .clk(clk), .rst_n(rst_n), .ts(ts), .mark_valid(mark_valid), .mark_code(mark_code),
        .acc_keep(acc_keep), .acc_write(acc_write), .acc_line(acc_line), .commit(push_ok),
        .grp_words(grp_words), .grp_cnt(grp_cnt)
    );

    trc_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_cnt(grp_cnt), .push_words(grp_words),
        .push_ok(push_ok), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .lost(lost)
    );
endmodule

// File: tb/sim_trc_formatter.sv
module sim_trc_formatter;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] ts = '0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [2:0]  acc_bank = '0;
    logic [12:0] acc_row = '0;
    logic [7:0]  acc_col = '0;
    logic        mark_valid = 1'b0;
    logic [15:0] mark_code = '0;
    logic        tx_valid, tx_ready = 1'b0, lost;
    logic [31:0] tx_data;

    always #5 clk = ~clk;

    trc_formatter #(.FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .ts(ts), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_bank(acc_bank), .acc_row(acc_row), .acc_col(acc_col), .mark_valid(mark_valid),
        .mark_code(mark_code), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .lost(lost)
    );

    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;
    string       ph = "R1";
    logic [31:0] expq[$];
    bit          m_have;
    logic        m_wr;
    logic [2:0]  m_bank;
    logic [12:0] m_row;
    logic [5:0]  m_win;
    logic [27:0] m_ref;
    bit          exp_lost;
    bit          hold_prev = 1'b0;
    logic [31:0] prev_data;

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (phase %s) act=%h exp=%h", req, ph, act, exp);
        end
    endtask

    function automatic string kind(logic [31:0] w);
        if (!w[31]) return "R2 R3 access word";
        if (w[30:28] == 3'b001) return "R4 overflow word";
        return "R6 tag word";
    endfunction

    task automatic model_reset();
        expq.delete();
        m_have = 0; m_wr = 0; m_bank = 0; m_row = 0; m_win = 0;
        m_ref = 0; exp_lost = 0; hold_prev = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; acc_valid = 0; mark_valid = 0; tx_ready = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        chk(tx_valid == 1'b0, "R1 tx_valid after reset", 32'(tx_valid), 0);
        chk(lost == 1'b0, "R1 lost after reset", 32'(lost), 0);
    endtask

    task automatic step(bit av, bit aw, logic [2:0] ab, logic [12:0] ar, logic [7:0] ac,
                        bit mv, logic [15:0] mc, bit rdy, int unsigned tinc);
        int          occ;
        bit          popped, keep, big;
        logic [27:0] nts, delta;
        logic [7:0]  dt;
        logic [31:0] grp[$];
        @(negedge clk);
        occ = expq.size();
        chk(tx_valid == (occ != 0), "R8 tx_valid tracks occupancy", 32'(tx_valid), 32'(occ != 0));
        chk(lost == exp_lost, "R9 lost flag", 32'(lost), 32'(exp_lost));
        if (hold_prev)
            chk(tx_data == prev_data, "R8 data held while stalled", tx_data, prev_data);
        popped = tx_valid && rdy && occ != 0;
        if (popped) chk(tx_data == expq[0], kind(expq[0]), tx_data, expq[0]);
        hold_prev = tx_valid && !rdy;
        prev_data = tx_data;
        nts = ts + 28'(tinc);
        ts = nts; acc_valid = av; acc_write = aw; acc_bank = ab; acc_row = ar; acc_col = ac;
        mark_valid = mv; mark_code = mc; tx_ready = rdy;
        keep = av && !(m_have && m_wr == aw && m_bank == ab && m_row == ar && m_win == ac[7:2]);
        if (av) begin m_have = 1; m_wr = aw; m_bank = ab; m_row = ar; m_win = ac[7:2]; end
        delta = nts - m_ref;
        big = delta > 28'd255;
        dt = big ? 8'd0 : delta[7:0];
        if (mv) begin
            if (big) grp.push_back({4'b1001, delta});
            grp.push_back({4'b1010, dt, 4'b0000, mc});
        end
        if (keep) begin
            if (mv) grp.push_back({1'b0, aw, 8'd0, ab, ar, ac[7:2]});
            else begin
                if (big) grp.push_back({4'b1001, delta});
                grp.push_back({1'b0, aw, dt, ab, ar, ac[7:2]});
            end
        end
        if (grp.size() != 0) begin
            if (DEPTH - occ >= grp.size()) begin
                foreach (grp[i]) expq.push_back(grp[i]);
                m_ref = nts;
            end else exp_lost = 1;
        end
        if (popped) void'(expq.pop_front());
    endtask

    task automatic acc(bit w, logic [2:0] b, logic [12:0] r, logic [7:0] c, int unsigned t);
        step(1, w, b, r, c, 0, 16'h0, 1, t);
    endtask

    task automatic idle(bit rdy);
        step(0, 0, 0, 0, 0, 0, 16'h0, rdy, 1);
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && expq.size() != 0; i++) idle(1);
        idle(1);
        chk(expq.size() == 0, "R8 all expected words delivered", 32'(expq.size()), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        ph = "R2 R3";
        acc(0, 3'd1, 13'h0123, 8'h10, 5);
        acc(1, 3'd2, 13'h1ABC, 8'h44, 17);
        acc(0, 3'd7, 13'h1FFF, 8'hFC, 1);
        acc(1, 3'd0, 13'h0000, 8'h00, 0);
        drain();

        ph = "R4";
        acc(0, 3'd3, 13'h0042, 8'h20, 255);
        acc(0, 3'd3, 13'h0043, 8'h20, 256);
        acc(1, 3'd4, 13'h0044, 8'h20, 100000);
        drain();

        ph = "R5";
        acc(0, 3'd5, 13'h0100, 8'h40, 2);
        acc(0, 3'd5, 13'h0100, 8'h41, 2);
        acc(0, 3'd5, 13'h0100, 8'h42, 2);
        acc(0, 3'd5, 13'h0100, 8'h43, 2);
        acc(0, 3'd5, 13'h0100, 8'h44, 2);
        acc(1, 3'd5, 13'h0100, 8'h45, 2);
        acc(1, 3'd6, 13'h0100, 8'h45, 2);
        acc(1, 3'd6, 13'h0101, 8'h45, 2);
        drain();

        ph = "R6";
        step(0, 0, 0, 0, 0, 1, 16'hBEEF, 1, 9);
        step(0, 0, 0, 0, 0, 1, 16'h0001, 1, 5000);
        acc(0, 3'd1, 13'h0001, 8'h00, 3);
        drain();

        ph = "R7";
        step(1, 1, 3'd2, 13'h0777, 8'h80, 1, 16'h1234, 1, 7);
        step(1, 0, 3'd2, 13'h0778, 8'h80, 1, 16'h4321, 1, 700);
        drain();

        ph = "R9";
        for (int i = 0; i < 12; i++) step(1, 0, 3'd0, 13'(i), 8'h00, 0, 16'h0, 0, 300);
        idle(0);
        idle(0);
        drain();
        acc(0, 3'd0, 13'h0055, 8'h00, 1);
        drain();

        do_reset();
        ph = "random";
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            bit          av, mv, rdy;
            int unsigned t;
            av  = ($urandom % 4) != 0;
            mv  = ($urandom % 16) == 0;
            rdy = ($urandom % 8) != 0;
            t   = (($urandom % 32) == 0) ? ($urandom % 2000) : ($urandom % 40);
            step(av, 1'($urandom), 3'($urandom % 2), 13'($urandom % 2), 8'($urandom % 12),
                 mv, 16'($urandom), rdy, t);
        end
        drain();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule